// File: doc/BRIEF.md
# Integer twin butterfly rounding multiplier

This block is the fixed-point core of a DCT/FFT butterfly step. A single issued operation carries three signed register values `a`, `b` and `c` and a 32-bit instruction word. The block forms both the sum `a+b` and the difference `a-b`, multiplies each by the coefficient `c`, adds half of the last kept bit and shifts arithmetically right by an amount `n` taken from an immediate field of the instruction. Each result is then cut back to the register width. Two results leave in the same cycle: the sum-path value for the destination register named in the instruction, and the difference-path value for the register that follows it.

The datapath has two register stages. The first stage forms the two products at full precision. The second stage rounds, shifts and truncates them. Valid travels with the data. An operation whose record bit is set is a reserved encoding. It produces no results and raises an illegal flag instead. In the usual codec case, 16-bit samples are multiplied by fixed cosine constants and the shift is 14.

Top module: `twin_bfly_rmul`

## Requirements
- R1: For 1 <= n <= 31, `res_sum_o` equals the low XLEN bits of ((a+b)*c + 2^(n-1)) >> n. The operands and the product are signed, the shift is arithmetic, and ties round upward, toward plus infinity.
- R2: For 1 <= n <= 31, `res_diff_o` equals the low XLEN bits of ((a-b)*c + 2^(n-1)) >> n. It uses the same a, b and c as R1, taken in the same operation.
- R3: When n = 0, nothing is added and nothing is shifted. The outputs are the low XLEN bits of (a+b)*c and of (a-b)*c.
- R4: n is the 5-bit field `insn_i[10:6]`. Bit numbering counts `insn_i[31]` as instruction bit 0, so in that numbering the field is bits 21 to 25. The opcode field `insn_i[31:26]`, the RA field `insn_i[20:16]`, the RB field `insn_i[15:11]` and the extended opcode field `insn_i[5:1]` do not affect the results.
- R5: An accepted operation raises `valid_o` for exactly one cycle, two rising edges after the edge that sampled `valid_i`, with both results present in that cycle. Back-to-back operations are accepted on consecutive cycles.
- R6: With `valid_o` high, `dst_sum_o` equals the destination field `insn_i[25:21]` of that operation, and `dst_diff_o` equals that field plus one, modulo 32.
- R7: When `insn_i[0]` (the record bit) is 1, `illegal_o` pulses two edges after the operation is issued. In that cycle `valid_o` stays low and both results read zero.
- R8: Whenever `valid_o` is low, including after reset, both results read zero. Reset also clears `valid_o` and `illegal_o`.
- R9: Intermediates do not overflow. With a = b = c = most negative value, the results follow R1 to R3 using exact arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation issued this cycle |
| insn_i | input | 32 | Instruction word |
| a_i | input | XLEN | Signed operand a |
| b_i | input | XLEN | Signed operand b |
| c_i | input | XLEN | Signed coefficient c |
| valid_o | output | 1 | Results valid |
| illegal_o | output | 1 | Reserved encoding rejected |
| res_sum_o | output | XLEN | Rounded sum-path product |
| res_diff_o | output | XLEN | Rounded difference-path product |
| dst_sum_o | output | 5 | Destination index for the sum result |
| dst_diff_o | output | 5 | Destination index for the difference result, destination + 1 |

## Verification
Every result is due on the second rising edge after the edge that samples `valid_i`, one edge for the products and one for rounding. The bench drives inputs on falling edges. It checks that `valid_o` is still low after the first edge, then samples the results, the destination indices and `illegal_o` at the falling edge after the second edge. A back-to-back pair is checked on consecutive cycles to confirm that the stages overlap and that neither operation holds up the other.

// File: rtl/twin_bfly_pkg.sv
package twin_bfly_pkg;
  localparam int unsigned IW   = 32;
  localparam int unsigned REGW = 5;
  localparam int unsigned SHW  = 5;

  // Field order follows the word from its most significant bit down
  typedef struct packed {
    logic [5:0]      opc;
    logic [REGW-1:0] rt;
    logic [REGW-1:0] ra;
    logic [REGW-1:0] rb;
    logic [SHW-1:0]  sh;
    logic [4:0]      xo;
    logic            rc;
  } insn_t;

  typedef enum logic {LANE_SUM = 1'b0, LANE_DIFF = 1'b1} lane_e;
endpackage

// File: rtl/twin_bfly_mul.sv
module twin_bfly_mul #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned PW  = 2 * XLEN + 2
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] c_i,
  output logic [PW-1:0]   prod_o [2]
);
  import twin_bfly_pkg::*;

  logic signed [XLEN:0]   a_x, b_x;
  logic signed [XLEN-1:0] c_s;

  assign a_x = {a_i[XLEN-1], a_i};
  assign b_x = {b_i[XLEN-1], b_i};
  assign c_s = c_i;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic signed [XLEN:0] op;
    logic signed [PW-1:0] p;
    if (lane_e'(l) == LANE_SUM) begin : g_sum
      assign op = a_x + b_x;
    end else begin : g_diff
      assign op = a_x - b_x;
    end
    assign p         = op * c_s;
    assign prod_o[l] = p;
  end
endmodule

// File: rtl/twin_bfly_rnd.sv
module twin_bfly_rnd #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned SHW  = 5,
  localparam int unsigned PW  = 2 * XLEN + 2
) (
  input  logic [PW-1:0]   prod_i,
  input  logic [SHW-1:0]  n_i,
  output logic [XLEN-1:0] res_o
);
  logic signed [PW-1:0] half, biased, shifted;

  always_comb begin
    half = '0;
    if (n_i != '0) half = PW'(1) << (n_i - SHW'(1));
    biased  = $signed(prod_i) + half;
    shifted = biased >>> n_i;
  end

  assign res_o = shifted[XLEN-1:0];

  // R3
  always_comb begin
    zero_shift_chk: assert (n_i != '0 || biased == $signed(prod_i));
  end
endmodule

// File: rtl/twin_bfly_rmul.sv
module twin_bfly_rmul #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned PW  = 2 * XLEN + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] c_i,
  output logic            valid_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] res_sum_o,
  output logic [XLEN-1:0] res_diff_o,
  output logic [4:0]      dst_sum_o,
  output logic [4:0]      dst_diff_o
);
  import twin_bfly_pkg::*;

  insn_t ins;
  assign ins = insn_t'(insn_i);

  logic [PW-1:0]   prod [2];
  logic [PW-1:0]   s1_prod [2];
  logic [SHW-1:0]  s1_n;
  logic [REGW-1:0] s1_rt;
  logic            s1_vld, s1_ill;
  logic [XLEN-1:0] rnd [2];

  twin_bfly_mul #(.XLEN(XLEN)) u_mul (
    .a_i    (a_i),
    .b_i    (b_i),
    .c_i    (c_i),
    .prod_o (prod)
  );

  // Stage 1: products
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_prod[0] <= '0;
      s1_prod[1] <= '0;
      s1_n       <= '0;
      s1_rt      <= '0;
      s1_vld     <= 1'b0;
      s1_ill     <= 1'b0;
    end else begin
      s1_vld <= valid_i & ~ins.rc;
      s1_ill <= valid_i & ins.rc;
      if (valid_i) begin
        s1_prod[0] <= prod[0];
        s1_prod[1] <= prod[1];
        s1_n       <= ins.sh;
        s1_rt      <= ins.rt;
      end
    end
  end

  for (genvar l = 0; l < 2; l++) begin : g_rnd
    twin_bfly_rnd #(.XLEN(XLEN), .SHW(SHW)) u_rnd (
      .prod_i (s1_prod[l]),
      .n_i    (s1_n),
      .res_o  (rnd[l])
    );
  end

  // Stage 2: round, shift, pair
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      illegal_o  <= 1'b0;
      res_sum_o  <= '0;
      res_diff_o <= '0;
      dst_sum_o  <= '0;
      dst_diff_o <= '0;
    end else begin
      valid_o   <= s1_vld;
      illegal_o <= s1_ill;
      if (s1_vld) begin
        res_sum_o  <= rnd[LANE_SUM];
        res_diff_o <= rnd[LANE_DIFF];
        dst_sum_o  <= s1_rt;
        dst_diff_o <= s1_rt + REGW'(1);
      end else begin
        res_sum_o  <= '0;
        res_diff_o <= '0;
      end
    end
  end

  // R5
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !insn_i[0]) |=> ##1 valid_o);
  // R6
  dst_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (dst_sum_o == $past(insn_i[25:21], 2)));
  // R7
  illegal_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[0]) |=> ##1 (illegal_o && !valid_o));
  // R7
  illegal_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && illegal_o));
  // R8
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (res_sum_o == '0 && res_diff_o == '0));
endmodule

// File: tb/twin_bfly_rmul_test.sv
`timescale 1ns/1ps
module twin_bfly_rmul_test;
  localparam int XW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [31:0]   insn_i = '0;
  logic [XW-1:0] a_i = '0, b_i = '0, c_i = '0;
  logic          valid_o, illegal_o;
  logic [XW-1:0] res_sum_o, res_diff_o;
  logic [4:0]    dst_sum_o, dst_diff_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  twin_bfly_rmul uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .insn_i(insn_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .valid_o(valid_o), .illegal_o(illegal_o),
    .res_sum_o(res_sum_o), .res_diff_o(res_diff_o),
    .dst_sum_o(dst_sum_o), .dst_diff_o(dst_diff_o)
  );

  typedef struct packed {
    logic [63:0] a, b, c;
    logic [4:0]  n;
    logic [63:0] es, ed;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{64'd100,  64'd50, 64'd11585, 5'd14, 64'd106,  64'd35},
    '{-64'sd100, 64'd50, 64'd11585, 5'd14, -64'sd35, -64'sd106},
    '{64'd3,    64'd2,  -64'sd7,   5'd0,  -64'sd35, -64'sd7},
    '{64'd1,    64'd0,  64'd1,     5'd1,  64'd1,    64'd1},
    '{-64'sd1,  64'd0,  64'd1,     5'd1,  64'd0,    64'd0},
    '{64'd5,    -64'sd1, 64'd1,    5'd2,  64'd1,    64'd2}
  };

  function automatic logic [63:0] ref_fn(bit diff, logic [63:0] a, logic [63:0] b,
                                         logic [63:0] c, logic [4:0] n);
    logic signed [129:0] x, y, z, p;
    x = 130'($signed(a));
    y = 130'($signed(b));
    z = 130'($signed(c));
    p = (diff ? (x - y) : (x + y)) * z;
    if (n != 0) p = (p + (130'sd1 <<< (n - 1))) >>> n;
    return p[63:0];
  endfunction

  function automatic logic [31:0] mk_insn(logic [4:0] rt, logic [4:0] n, logic rc);
    return {6'd4, rt, 5'd7, 5'd9, n, 5'd24, rc};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [63:0] a, logic [63:0] b, logic [63:0] c, logic [31:0] w);
    valid_i = 1'b1; insn_i = w; a_i = a; b_i = b; c_i = c;
  endtask

  // Issue one operation at a falling edge, check at the falling edge after the second rise
  task automatic run_op(string tag, logic [63:0] a, logic [63:0] b, logic [63:0] c,
                        logic [4:0] n, logic [4:0] rt, logic [63:0] es, logic [63:0] ed);
    drive(a, b, c, mk_insn(rt, n, 1'b0));
    @(posedge clk); @(negedge clk);
    valid_i = 1'b0;
    chk({tag, " R5 early"}, 64'(valid_o), 64'd0);
    @(posedge clk); @(negedge clk);
    chk({tag, " R5 valid"}, 64'(valid_o), 64'd1);
    chk({tag, " R1 sum"}, res_sum_o, es);
    chk({tag, " R2 diff"}, res_diff_o, ed);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        errors++;
        $display("FAIL watchdog act=%0d exp=<100000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 valid", 64'(valid_o), 64'd0);
    chk("R8 illegal", 64'(illegal_o), 64'd0);
    chk("R8 sum", res_sum_o, 64'd0);
    chk("R8 diff", res_diff_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 vector table
    foreach (VECS[i]) begin
      run_op("vec", VECS[i].a, VECS[i].b, VECS[i].c, VECS[i].n, 5'd3, VECS[i].es, VECS[i].ed);
      chk("R6 dst_sum", 64'(dst_sum_o), 64'd3);
      chk("R6 dst_diff", 64'(dst_diff_o), 64'd4);
    end

    // R4 every shift, random operands
    for (int n = 0; n < 32; n++) begin
      logic [63:0] a, b, c;
      a = 64'($signed(16'($urandom())));
      b = 64'($signed(16'($urandom())));
      c = 64'($signed(16'($urandom())));
      run_op("R4 shift", a, b, c, 5'(n), 5'(n),
             ref_fn(1'b0, a, b, c, 5'(n)), ref_fn(1'b1, a, b, c, 5'(n)));
    end

    // R1 R2 wide random operands
    for (int k = 0; k < 40; k++) begin
      logic [63:0] a, b, c;
      logic [4:0]  n;
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      c = {$urandom(), $urandom()};
      n = 5'($urandom());
      run_op("rand", a, b, c, n, 5'd10, ref_fn(1'b0, a, b, c, n), ref_fn(1'b1, a, b, c, n));
    end

    // R9 extreme negatives
    for (int n = 0; n < 32; n += 7) begin
      logic [63:0] m;
      m = 64'h8000_0000_0000_0000;
      run_op("R9 minneg", m, m, m, 5'(n), 5'd1, ref_fn(1'b0, m, m, m, 5'(n)),
             ref_fn(1'b1, m, m, m, 5'(n)));
      run_op("R9 mixed", m, 64'h7fff_ffff_ffff_ffff, m, 5'(n), 5'd1,
             ref_fn(1'b0, m, 64'h7fff_ffff_ffff_ffff, m, 5'(n)),
             ref_fn(1'b1, m, 64'h7fff_ffff_ffff_ffff, m, 5'(n)));
    end

    // R6 wrap of destination index
    run_op("R6 wrap", 64'd8, 64'd2, 64'd3, 5'd1, 5'd31, 64'd15, 64'd9);
    chk("R6 wrap dst_sum", 64'(dst_sum_o), 64'd31);
    chk("R6 wrap dst_diff", 64'(dst_diff_o), 64'd0);

    // R4 unrelated fields ignored
    drive(64'd9, 64'd3, 64'd5, {6'h3f, 5'd2, 5'd31, 5'd31, 5'd2, 5'd31, 1'b0});
    @(posedge clk); @(negedge clk);
    valid_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R4 ignore sum", res_sum_o, 64'd15);
    chk("R4 ignore diff", res_diff_o, 64'd8);

    // R7 reserved record form
    drive(64'd100, 64'd50, 64'd11585, mk_insn(5'd6, 5'd14, 1'b1));
    @(posedge clk); @(negedge clk);
    valid_i = 1'b0;
    chk("R7 early", 64'(illegal_o), 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R7 illegal", 64'(illegal_o), 64'd1);
    chk("R7 no valid", 64'(valid_o), 64'd0);
    chk("R7 sum zero", res_sum_o, 64'd0);
    chk("R7 diff zero", res_diff_o, 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R7 pulse", 64'(illegal_o), 64'd0);

    // R5 back-to-back pair
    drive(64'd1, 64'd0, 64'd1, mk_insn(5'd12, 5'd1, 1'b0));
    @(posedge clk); @(negedge clk);
    drive(64'd5, -64'sd1, 64'd1, mk_insn(5'd20, 5'd2, 1'b0));
    @(posedge clk); @(negedge clk);
    valid_i = 1'b0;
    chk("R5 b2b first valid", 64'(valid_o), 64'd1);
    chk("R5 b2b first sum", res_sum_o, 64'd1);
    chk("R5 b2b first dst", 64'(dst_sum_o), 64'd12);
    @(posedge clk); @(negedge clk);
    chk("R5 b2b second valid", 64'(valid_o), 64'd1);
    chk("R5 b2b second diff", res_diff_o, 64'd2);
    chk("R5 b2b second dst", 64'(dst_diff_o), 64'd21);
    @(posedge clk); @(negedge clk);
    chk("R5 single pulse", 64'(valid_o), 64'd0);
    chk("R8 idle sum", res_sum_o, 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule